// File: doc/BRIEF.md
# Justified-Format Stereo Audio Serial Port

This block moves stereo audio samples between parallel buses and a pair of serial data lines. Each frame of the channel-select clock (here called the frame clock) carries one left sample while the frame clock is low and one right sample while it is high. Bits move on a bit clock. The most significant bit goes first. Outgoing data changes after a falling bit-clock edge. Incoming data is captured on a rising edge. A run-time input places each word at the start of its half-frame (left-justified) or at the end of it (right-justified). The word length can be 16, 20, 24 or 32 bits.

The port runs entirely on the master clock. In master mode it divides the master clock to produce the bit clock and the frame clock, with a fixed number of bit slots per half-frame. In slave mode it takes both clocks from outside, passes them and the record data through two-flop synchronizers, and detects their edges in the master clock domain. Outgoing sample pairs are taken with a valid/ready handshake at the start of each left half. A received pair is offered on the receive bus once its right half has ended. When the frame clock toggles before a full word has been captured, the partial word is dropped and a one-cycle error pulse is raised.

Top module: `audio_sport`

## Requirements
- R1: While the reset is held and on the first cycle after it, bclk_o, lrclk_o, pb_data_o, tx_ready_o, rx_valid_o and err_o are all 0.
- R2: In master mode the bit clock stays high for BCLK_HALF master clock cycles and low for BCLK_HALF cycles. The frame clock toggles only together with a falling bit clock, once every SLOTS bit-clock periods. Frame clock low means the left channel.
- R3: With rjust_i=0, the word's MSB goes in the first bit slot after the frame clock edge and the following slots carry the remaining bits down to the LSB. Every later slot in that half is driven 0.
- R4: With rjust_i=1, the word's LSB goes in the last of the SLOTS slots before the next frame clock edge. Every slot before the MSB is driven 0.
- R5: wlen_i selects the word length: 0 gives 16 bits, 1 gives 20, 2 gives 24 and 3 gives 32. Transmit bits at and above the word length are ignored. Received words appear right-aligned and zero-extended on the 32-bit receive bus.
- R6: tx_ready_o is high for exactly one cycle at the start of each left half, once the port has seen one frame clock edge. A pair offered with tx_valid_i in that cycle is sent in that frame. If none is offered, zeros are sent.
- R7: Record bits are captured on rising bit-clock edges. A pair is offered on rx_valid_o once its right half ends. rx_valid_o and the data stay put until rx_ready_i is high, and a newer pair replaces an unaccepted one.
- R8: In slave mode the port frames and moves data from the external bit clock and frame clock after resynchronization, with the same placement rules as master mode.
- R9: A frame clock edge that ends a half holding fewer captured bits than the word length drops that word and its frame, and pulses err_o for one cycle. The first edge after reset never raises err_o.
- R10: pb_data_o changes only in the cycle after a detected falling bit-clock edge or frame clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1: generate the clocks, 0: take them from the pins |
| rjust_i | input | 1 | 0: left-justified, 1: right-justified |
| wlen_i | input | 2 | Word length code (R5) |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| rec_data_i | input | 1 | Serial record data |
| bclk_o | output | 1 | Generated bit clock (0 in slave mode) |
| lrclk_o | output | 1 | Generated frame clock (0 in slave mode) |
| pb_data_o | output | 1 | Serial playback data |
| tx_left_i | input | DW | Left playback sample |
| tx_right_i | input | DW | Right playback sample |
| tx_valid_i | input | 1 | Playback pair offered |
| tx_ready_o | output | 1 | Playback pair taken this cycle |
| rx_left_o | output | DW | Left record sample |
| rx_right_o | output | DW | Right record sample |
| rx_valid_o | output | 1 | Record pair available |
| rx_ready_i | input | 1 | Record pair accepted |
| err_o | output | 1 | Short half-frame pulse |

## Verification
On every cycle the assertions check the pulse shape of tx_ready_o and err_o, that receive data holds while it is not accepted, that playback data moves only after a detected falling edge, and that the generated frame clock moves only with a falling bit clock. Bit placement for each justification and word length, the masking of unused bits, zero fill when no pair is offered, and dropping a frame after a short half can only be shown by the bench. It loops playback back into record in both modes, records the serial pattern of a half-frame, and counts the received pairs and error pulses.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int unsigned WLEN_CODES = 4;

  function automatic int wlen_bits(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int unsigned HALF  = 4,
  parameter int unsigned SLOTS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bclk_o,
  output logic lrclk_o
);
  localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SW   = $clog2(SLOTS);
  localparam logic [DIVW-1:0] DIV_MAX  = DIVW'(HALF - 1);
  localparam logic [SW-1:0]   SLOT_MAX = SW'(SLOTS - 1);

  logic [DIVW-1:0] div_q;
  logic [SW-1:0]   slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      slot_q  <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else if (!en_i) begin
      div_q   <= '0;
      slot_q  <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else if (div_q == DIV_MAX) begin
      div_q  <= '0;
      bclk_o <= ~bclk_o;
      if (bclk_o) begin  // falling edge: advance slot, frame clock turns here
        if (slot_q == SLOT_MAX) begin
          slot_q  <= '0;
          lrclk_o <= ~lrclk_o;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int unsigned DW    = 32,
  parameter int unsigned SLOTS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rjust_i,
  input  logic [1:0]    wlen_i,
  input  logic          edge_i,
  input  logic          lr_i,
  input  logic          fall_i,
  input  logic          synced_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          sd_o
);
  localparam int SW = $clog2(SLOTS);
  localparam int IW = $clog2(DW);
  localparam logic [SW-1:0] SLOT_MAX = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q, slot_d;
  logic [DW-1:0] cur_q, cur_d, rbuf_q;
  logic          step;

  // bit index of the word that falls in slot s; out of range means fill
  function automatic logic pick(logic [DW-1:0] w, int s, logic rj, int wl);
    int idx;
    idx = rj ? (int'(SLOTS) - 1 - s) : (wl - 1 - s);
    if (idx >= 0 && idx < wl) return w[IW'(idx)];
    return 1'b0;
  endfunction

  assign ready_o = edge_i & ~lr_i & synced_i;
  assign step    = edge_i | fall_i;

  always_comb begin
    slot_d = slot_q;
    cur_d  = cur_q;
    if (edge_i) begin
      slot_d = '0;
      cur_d  = lr_i ? rbuf_q : ((ready_o && valid_i) ? left_i : '0);
    end else if (fall_i && slot_q != SLOT_MAX) begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      cur_q  <= '0;
      rbuf_q <= '0;
      sd_o   <= 1'b0;
    end else begin
      if (step) begin
        slot_q <= slot_d;
        cur_q  <= cur_d;
        sd_o   <= pick(cur_d, int'(slot_d), rjust_i, wlen_bits(wlen_i));
      end
      if (ready_o) rbuf_q <= valid_i ? right_i : '0;
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx import sport_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rjust_i,
  input  logic [1:0]    wlen_i,
  input  logic          edge_i,
  input  logic          lr_old_i,
  input  logic          rise_i,
  input  logic          sd_i,
  input  logic          ready_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          err_o,
  output logic          synced_o,
  output logic          pair_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DW);

  logic [DW-1:0] sh_q, lbuf_q, mask;
  logic [CW-1:0] cnt_q;
  logic          l_ok_q, complete;
  int            wl;

  always_comb begin
    wl       = wlen_bits(wlen_i);
    mask     = {DW{1'b1}} >> (int'(DW) - wl);
    complete = int'(cnt_q) >= wl;
  end

  assign pair_o = edge_i & lr_old_i & synced_o & complete & l_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      lbuf_q   <= '0;
      l_ok_q   <= 1'b0;
      synced_o <= 1'b0;
      err_o    <= 1'b0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (edge_i) begin
        sh_q     <= '0;
        cnt_q    <= '0;
        synced_o <= 1'b1;
        err_o    <= synced_o & ~complete;
        if (!lr_old_i) begin
          lbuf_q <= sh_q & mask;
          l_ok_q <= synced_o & complete;
        end else begin
          l_ok_q <= 1'b0;
          if (pair_o) begin
            left_o  <= lbuf_q;
            right_o <= sh_q & mask;
          end
        end
      end else if (rise_i) begin
        // left-justified stops after the word; right-justified keeps the last bits
        if (rjust_i || int'(cnt_q) < wl) sh_q <= {sh_q[DW-2:0], sd_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (pair_o)                  valid_o <= 1'b1;
      else if (valid_o && ready_i) valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_sport.sv
module audio_sport #(
  parameter int unsigned DW        = 32,
  parameter int unsigned SLOTS     = 32,
  parameter int unsigned BCLK_HALF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          rjust_i,
  input  logic [1:0]    wlen_i,
  input  logic          bclk_i,
  input  logic          lrclk_i,
  input  logic          rec_data_i,
  output logic          bclk_o,
  output logic          lrclk_o,
  output logic          pb_data_o,
  input  logic [DW-1:0] tx_left_i,
  input  logic [DW-1:0] tx_right_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_left_o,
  output logic [DW-1:0] rx_right_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic          err_o
);
  logic [2:0] sync_q;
  logic       gen_bclk, gen_lr;
  logic       src_b, src_l, b_d1_q, l_d1_q;
  logic       fall_s, rise_s, edge_s, step_s, synced_s, pair_s;

  sport_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rec_data_i, lrclk_i, bclk_i}),
    .q_o    (sync_q)
  );

  sport_clkgen #(.HALF(BCLK_HALF), .SLOTS(SLOTS)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (master_i),
    .bclk_o  (gen_bclk),
    .lrclk_o (gen_lr)
  );

  assign bclk_o  = gen_bclk;
  assign lrclk_o = gen_lr;
  assign src_b   = master_i ? gen_bclk : sync_q[0];
  assign src_l   = master_i ? gen_lr   : sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_d1_q <= 1'b0;
      l_d1_q <= 1'b0;
    end else begin
      b_d1_q <= src_b;
      l_d1_q <= src_l;
    end
  end

  assign fall_s = b_d1_q & ~src_b;
  assign rise_s = ~b_d1_q & src_b;
  assign edge_s = l_d1_q ^ src_l;
  assign step_s = fall_s | edge_s;

  sport_tx #(.DW(DW), .SLOTS(SLOTS)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rjust_i  (rjust_i),
    .wlen_i   (wlen_i),
    .edge_i   (edge_s),
    .lr_i     (src_l),
    .fall_i   (fall_s),
    .synced_i (synced_s),
    .left_i   (tx_left_i),
    .right_i  (tx_right_i),
    .valid_i  (tx_valid_i),
    .ready_o  (tx_ready_o),
    .sd_o     (pb_data_o)
  );

  sport_rx #(.DW(DW)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rjust_i  (rjust_i),
    .wlen_i   (wlen_i),
    .edge_i   (edge_s),
    .lr_old_i (l_d1_q),
    .rise_i   (rise_s),
    .sd_i     (sync_q[2]),
    .ready_i  (rx_ready_i),
    .left_o   (rx_left_o),
    .right_o  (rx_right_o),
    .valid_o  (rx_valid_o),
    .err_o    (err_o),
    .synced_o (synced_s),
    .pair_o   (pair_s)
  );
endmodule

// File: rtl/audio_sport_chk.sv
module audio_sport_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic          bclk_o,
  input logic          lrclk_o,
  input logic          pb_data_o,
  input logic          tx_ready_o,
  input logic          rx_valid_o,
  input logic          rx_ready_i,
  input logic [DW-1:0] rx_left_o,
  input logic          err_o,
  input logic          step_s,
  input logic          pair_s
);
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);  // R9
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);  // R6
  AST_RX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);  // R7
  AST_RX_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i && !pair_s |=> $stable(rx_left_o));  // R7
  AST_PB_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pb_data_o) |-> $past(step_s));  // R10
  AST_LR_ON_BCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && (lrclk_o != $past(lrclk_o)) |-> ($past(bclk_o) && !bclk_o));  // R2
endmodule

bind audio_sport audio_sport_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .master_i   (master_i),
  .bclk_o     (bclk_o),
  .lrclk_o    (lrclk_o),
  .pb_data_o  (pb_data_o),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_left_o  (rx_left_o),
  .err_o      (err_o),
  .step_s     (step_s),
  .pair_s     (pair_s)
);

// File: tb/audio_sport_tb.sv
module audio_sport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SLOTS      = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b1, rjust = 1'b0;
  logic [1:0]  wlen = 2'd0;
  logic        bclk_s = 1'b0, lr_s = 1'b0;
  logic        bclk_o, lrclk_o, pb_data_o;
  logic [31:0] tx_l = '0, tx_r = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [31:0] rx_l, rx_r;
  logic        rx_valid, rx_ready = 1'b1, err_o;

  int total = 0, bad = 0, rx_cnt = 0, err_cnt = 0;
  logic [31:0] last_l = '0, last_r = '0, ser = '0, snap_l = '0;
  logic        prev_b = 1'b0, prev_lr = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_sport u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .rjust_i(rjust), .wlen_i(wlen),
    .bclk_i(bclk_s), .lrclk_i(lr_s), .rec_data_i(pb_data_o),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .pb_data_o(pb_data_o),
    .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rx_valid && rx_ready) begin
      rx_cnt = rx_cnt + 1;
      last_l = rx_l;
      last_r = rx_r;
    end
    if (err_o) err_cnt = err_cnt + 1;
    if (bclk_o && !prev_b) ser = {ser[30:0], pb_data_o};
    if (lrclk_o != prev_lr && !prev_lr) snap_l = ser;
    prev_b  = bclk_o;
    prev_lr = lrclk_o;
  end

  function automatic int bits(logic [1:0] c);
    case (c)
      2'd0: return 16;
      2'd1: return 20;
      2'd2: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(logic [1:0] c);
    return (bits(c) == 32) ? 32'hFFFF_FFFF : ((32'h1 << bits(c)) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic m, logic rj, logic [1:0] wl);
    rst_n  = 1'b0;
    master = m;
    rjust  = rj;
    wlen   = wl;
    bclk_s = 1'b0;
    lr_s   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_pairs(int n);
    int base = rx_cnt;
    while (rx_cnt < base + n) @(negedge clk);
  endtask

  task automatic slave_half(int nbits);
    for (int b = 0; b < nbits; b++) begin
      bclk_s = 1'b0;
      if (b == 0) lr_s = ~lr_s;
      repeat (HALF) @(negedge clk);
      bclk_s = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    master = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rx_valid in reset", {31'd0, rx_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bclk_o", {31'd0, bclk_o}, 32'd0);
    chk("R1 lrclk_o", {31'd0, lrclk_o}, 32'd0);
    chk("R1 pb_data_o", {31'd0, pb_data_o}, 32'd0);
    chk("R1 tx_ready_o", {31'd0, tx_ready}, 32'd0);
    chk("R1 rx_valid_o", {31'd0, rx_valid}, 32'd0);
    chk("R1 err_o", {31'd0, err_o}, 32'd0);
  endtask

  task automatic t_master_clocks();
    int n;
    logic p;
    do_reset(1'b1, 1'b0, 2'd3);
    p = lrclk_o;
    while (lrclk_o == p) @(negedge clk);
    p = lrclk_o;
    n = 0;
    while (lrclk_o == p) begin @(negedge clk); n++; end
    chk("R2 frame clock half period", n, SLOTS * 2 * HALF);
    while (!bclk_o) @(negedge clk);
    n = 0;
    while (bclk_o) begin @(negedge clk); n++; end
    chk("R2 bit clock high time", n, HALF);
  endtask

  // loopback of playback into record; serial pattern checked in master mode
  task automatic t_loop(string req, logic m, logic rj, logic [1:0] wl,
                        logic [31:0] l, logic [31:0] r);
    int e0;
    logic [31:0] mk, pat;
    do_reset(m, rj, wl);
    tx_l = l;
    tx_r = r;
    tx_valid = 1'b1;
    e0 = err_cnt;
    mk = mask_of(wl);
    if (m) wait_pairs(3);
    else for (int h = 0; h < 11; h++) slave_half(SLOTS);
    repeat (20) @(negedge clk);
    chk({req, " R5 left word"}, last_l, l & mk);
    chk({req, " R5 right word"}, last_r, r & mk);
    chk({req, " R9 no error"}, err_cnt - e0, 0);
    if (m) begin
      pat = rj ? (l & mk) : ((l & mk) << (32 - bits(wl)));
      chk({req, " serial left half"}, snap_l, pat);
    end
    tx_valid = 1'b0;
  endtask

  task automatic t_idle();
    do_reset(1'b1, 1'b0, 2'd0);
    tx_valid = 1'b0;
    last_l = 32'hDEAD_BEEF;
    last_r = 32'hDEAD_BEEF;
    wait_pairs(2);
    chk("R6 idle left zero", last_l, 32'd0);
    chk("R6 idle right zero", last_r, 32'd0);
  endtask

  task automatic t_hold();
    int drops = 0;
    logic [31:0] v;
    rx_ready = 1'b0;
    do_reset(1'b1, 1'b0, 2'd3);
    tx_l = 32'h1357_9BDF;
    tx_r = 32'h2468_ACE0;
    tx_valid = 1'b1;
    while (!rx_valid) @(negedge clk);
    v = rx_l;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (!rx_valid) drops++;
    end
    chk("R7 valid held without ready", drops, 0);
    chk("R7 held left data", v, 32'h1357_9BDF);
    chk("R7 held right data", rx_r, 32'h2468_ACE0);
    rx_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 valid drops after accept", {31'd0, rx_valid}, 32'd0);
    tx_valid = 1'b0;
  endtask

  task automatic t_short();
    int e0, p0;
    do_reset(1'b0, 1'b0, 2'd2);
    tx_l = 32'h00AB_CDEF;
    tx_r = 32'h0012_3456;
    tx_valid = 1'b1;
    e0 = err_cnt;
    p0 = rx_cnt;
    for (int h = 1; h <= 10; h++) slave_half((h == 6) ? 10 : SLOTS);
    repeat (20) @(negedge clk);
    chk("R9 one error pulse", err_cnt - e0, 1);
    chk("R9 frame dropped", rx_cnt - p0, 3);
    chk("R8 R9 recovered left", last_l, 32'h00AB_CDEF);
    tx_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_master_clocks();
    t_loop("R3 master lj24", 1'b1, 1'b0, 2'd2, 32'hA5C3_96F1, 32'h5A3C_690E);
    t_loop("R4 master rj16", 1'b1, 1'b1, 2'd0, 32'hFFFF_C0DE, 32'h1234_8001);
    t_loop("R4 master rj20", 1'b1, 1'b1, 2'd1, 32'hF00F_5A5A, 32'h0F0F_F0F0);
    t_loop("R8 slave lj32", 1'b0, 1'b0, 2'd3, 32'h8000_0001, 32'hCAFE_F00D);
    t_loop("R8 slave rj20", 1'b0, 1'b1, 2'd1, 32'h7FFF_FFFF, 32'h000A_BCDE);
    t_idle();
    t_hold();
    t_short();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule